// File: doc/BRIEF.md
# Programmable Threshold Comparator

This block compares an unsigned input code against programmable levels once per clock and keeps a one-bit result. A two-bit mode field selects one of three comparisons. The first is a plain comparison against a single threshold. The second is a hysteresis comparison, in which the high margin sets the result and the low margin clears it. The third is a window test between the two margins. The fourth mode code is illegal. It forces the result to zero and latches an error flag that stays set until reset.

The result is always visible on a status output, before any inversion. It also drives a pin model made of a data value and an output enable. Control inputs gate the pin with a block enable and an output enable, choose push-pull or open-drain drive, and can invert the polarity. In open-drain drive the pin is only pulled low and is otherwise released. Configuration inputs are held by surrounding register logic. They are not part of this block.

Top module: `thrcmp_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the result and the error flag. After reset the pin is released (`pin_oe` = 0, `pin_do` = 0).
- R2: With `cmp_en` = 0, the result is 0 from the next edge onward. The pin is released (`pin_oe` = 0, `pin_do` = 0) whatever the other controls are.
- R3: With `cmp_en` = 1 and `out_en` = 0, the pin is released (`pin_oe` = 0, `pin_do` = 0).
- R4: With `cmp_en` = 1, `out_en` = 1 and `od_sel` = 0 (push-pull), `pin_oe` = 1 and `pin_do` = result XOR `inv_en`.
- R5: With `cmp_en` = 1, `out_en` = 1 and `od_sel` = 1 (open-drain), the polarity is set by `inv_en` first. A resulting 0 gives `pin_oe` = 1 with `pin_do` = 0. A resulting 1 gives `pin_oe` = 0 with `pin_do` = 0.
- R6: Mode 2'b00 (plain): after each edge, the result is 1 exactly when `code_in` >= `thr_level`.
- R7: Mode 2'b01 (hysteresis): the result becomes 1 when `code_in` >= `margin_hi`. Otherwise it becomes 0 when `code_in` <= `margin_lo`. Otherwise it keeps its value. The set test has priority.
- R8: Mode 2'b10 (window): the result becomes 1 exactly when `margin_lo` < `code_in` < `margin_hi`.
- R9: Mode 2'b11 while enabled forces the result to 0 and sets `cfg_err`. `cfg_err` stays 1 until reset.
- R10: `status` always equals the stored result and is unaffected by `inv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_en | input | 1 | Comparator enable |
| out_en | input | 1 | Pin output enable |
| od_sel | input | 1 | 1 = open-drain drive, 0 = push-pull drive |
| inv_en | input | 1 | Invert the pin polarity |
| mode | input | 2 | 00 plain, 01 hysteresis, 10 window, 11 illegal |
| thr_level | input | WIDTH | Threshold used in plain mode |
| margin_hi | input | WIDTH | High margin (rising trip point, upper window bound) |
| margin_lo | input | WIDTH | Low margin (falling trip point, lower window bound) |
| code_in | input | WIDTH | Sampled unsigned input code |
| pin_do | output | 1 | Pin data value |
| pin_oe | output | 1 | Pin output enable |
| status | output | 1 | Comparator result before inversion |
| cfg_err | output | 1 | Sticky illegal-mode flag |

## Verification
The bench builds the block with WIDTH = 4, so every code is one of only sixteen values. With so few values, random codes regularly land exactly on `thr_level`, `margin_hi` and `margin_lo`. They also hit cases where the margins are equal or reversed. All the equality edges of the plain, hysteresis and window tests are therefore reached often. Random mode and control picks cross the illegal mode with later legal modes, which tests that the error flag stays set. Directed sequences walk the hysteresis band up and down.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN = 2'b00,
        MODE_HYST  = 2'b01,
        MODE_WIN   = 2'b10,
        MODE_BAD   = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        logic res;
        logic err;
    } cmp_state_t;

    typedef struct packed {
        logic oe;
        logic dout;
    } pin_drive_t;

endpackage

// File: rtl/thrcmp_core.sv
module thrcmp_core
    import thrcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] thr_level,
    input  logic [WIDTH-1:0] margin_hi,
    input  logic [WIDTH-1:0] margin_lo,
    input  logic [WIDTH-1:0] code_in,
    output logic             res,
    output logic             err
);

    cmp_state_t state_d, state_q;
    cmp_mode_e  mode_sel;
    logic       at_or_above_thr;
    logic       at_or_above_hi;
    logic       at_or_below_lo;
    logic       inside_win;

    always_comb begin
        mode_sel        = cmp_mode_e'(mode);
        at_or_above_thr = (code_in >= thr_level);
        at_or_above_hi  = (code_in >= margin_hi);
        at_or_below_lo  = (code_in <= margin_lo);
        inside_win      = (code_in > margin_lo) && (code_in < margin_hi);

        state_d = state_q;
        if (!en) begin
            state_d.res = 1'b0;
        end else begin
            unique case (mode_sel)
                MODE_PLAIN: state_d.res = at_or_above_thr;
                MODE_HYST: begin
                    if (at_or_above_hi) begin
                        state_d.res = 1'b1;
                    end else if (at_or_below_lo) begin
                        state_d.res = 1'b0;
                    end
                end
                MODE_WIN:  state_d.res = inside_win;
                MODE_BAD: begin
                    state_d.res = 1'b0;
                    state_d.err = 1'b1;
                end
                default:   state_d.res = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res = state_q.res;
    assign err = state_q.err;

    // R6: plain-mode result follows the threshold test one edge later
    p_plain_mode_r6: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b00) |=> (res == $past(code_in >= thr_level)));

    // R7: hysteresis set point
    p_hyst_set_r7: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b01 && code_in >= margin_hi) |=> res);

    // R7: hysteresis hold inside the band
    p_hyst_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b01 && code_in < margin_hi && code_in > margin_lo)
        |=> (res == $past(res)));

    // R8: window mode outside the bounds gives 0
    p_window_out_r8: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b10 && (code_in <= margin_lo || code_in >= margin_hi)) |=> !res);

    // R9: illegal mode forces 0 and raises the error
    p_bad_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (en && mode == 2'b11) |=> (!res && err));

    // R9: error flag is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R2: disabled comparator clears its result
    p_disabled_clear_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> !res);

endmodule

// File: rtl/thrcmp_pin_drive.sv
module thrcmp_pin_drive
    import thrcmp_pkg::*;
(
    input  logic en,
    input  logic out_en,
    input  logic od_sel,
    input  logic inv_en,
    input  logic res,
    output logic pin_do,
    output logic pin_oe
);

    pin_drive_t drive_d;
    logic       level;
    logic       gated;

    always_comb begin
        level   = res ^ inv_en;
        gated   = en && out_en;
        drive_d = '0;
        if (gated) begin
            if (od_sel) begin
                drive_d.oe   = !level;
                drive_d.dout = 1'b0;
            end else begin
                drive_d.oe   = 1'b1;
                drive_d.dout = level;
            end
        end
    end

    assign pin_do = drive_d.dout;
    assign pin_oe = drive_d.oe;

endmodule

// File: rtl/thrcmp_top.sv
module thrcmp_top
    import thrcmp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_en,
    input  logic             out_en,
    input  logic             od_sel,
    input  logic             inv_en,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] thr_level,
    input  logic [WIDTH-1:0] margin_hi,
    input  logic [WIDTH-1:0] margin_lo,
    input  logic [WIDTH-1:0] code_in,
    output logic             pin_do,
    output logic             pin_oe,
    output logic             status,
    output logic             cfg_err
);

    logic core_res;

    thrcmp_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .en        (cmp_en),
        .mode      (mode),
        .thr_level (thr_level),
        .margin_hi (margin_hi),
        .margin_lo (margin_lo),
        .code_in   (code_in),
        .res       (core_res),
        .err       (cfg_err)
    );

    thrcmp_pin_drive u_pin (
        .en     (cmp_en),
        .out_en (out_en),
        .od_sel (od_sel),
        .inv_en (inv_en),
        .res    (core_res),
        .pin_do (pin_do),
        .pin_oe (pin_oe)
    );

    assign status = core_res;

    // R2/R3: no drive unless both enables are set
    p_gated_release_r3: assert property (@(posedge clk) disable iff (rst)
        !(cmp_en && out_en) |-> (!pin_oe && !pin_do));

    // R5: open-drain never drives a high level
    p_od_no_high_r5: assert property (@(posedge clk) disable iff (rst)
        od_sel |-> !(pin_oe && pin_do));

    // R4: push-pull always drives when gated on
    p_pp_drives_r4: assert property (@(posedge clk) disable iff (rst)
        (cmp_en && out_en && !od_sel) |-> (pin_oe && (pin_do == (status ^ inv_en))));

endmodule

// File: tb/thrcmp_top_bench.sv
module thrcmp_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmp_en, out_en, od_sel, inv_en;
    logic [1:0]   mode;
    logic [W-1:0] thr_level, margin_hi, margin_lo, code_in;
    logic         pin_do, pin_oe, status, cfg_err;

    int  n_checks = 0;
    int  n_errors = 0;
    logic res_exp = 1'b0;
    logic err_exp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thrcmp_top #(.WIDTH(W)) u_thrcmp_top (
        .clk(clk), .rst(rst), .cmp_en(cmp_en), .out_en(out_en),
        .od_sel(od_sel), .inv_en(inv_en), .mode(mode),
        .thr_level(thr_level), .margin_hi(margin_hi), .margin_lo(margin_lo),
        .code_in(code_in), .pin_do(pin_do), .pin_oe(pin_oe),
        .status(status), .cfg_err(cfg_err)
    );

    function automatic logic model_next(input logic en, input logic [1:0] m,
            input logic [W-1:0] t, input logic [W-1:0] hi, input logic [W-1:0] lo,
            input logic [W-1:0] c, input logic prev);
        if (!en) return 1'b0;
        case (m)
            2'b00: return c >= t;
            2'b01: begin
                if (c >= hi) return 1'b1;
                if (c <= lo) return 1'b0;
                return prev;
            end
            2'b10: return (c > lo) && (c < hi);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        logic lvl;
        string st;
        lvl = res_exp ^ inv_en;
        case (mode)
            2'b00: st = "R6 status";
            2'b01: st = "R7 status";
            2'b10: st = "R8 status";
            default: st = "R9 status";
        endcase
        if (!cmp_en) st = "R2 status";
        check(st, status, res_exp);
        check("R9 cfg_err", cfg_err, err_exp);
        if (!cmp_en) begin
            check("R2 pin_oe", pin_oe, 1'b0);
            check("R2 pin_do", pin_do, 1'b0);
        end else if (!out_en) begin
            check("R3 pin_oe", pin_oe, 1'b0);
            check("R3 pin_do", pin_do, 1'b0);
        end else if (!od_sel) begin
            check("R4 pin_oe", pin_oe, 1'b1);
            check("R4 pin_do", pin_do, lvl);
        end else begin
            check("R5 pin_oe", pin_oe, !lvl);
            check("R5 pin_do", pin_do, 1'b0);
        end
    endtask

    // drive inputs, take one edge, update the model, check at the falling edge
    task automatic step(input logic r, input logic en, input logic oe, input logic od,
            input logic inv, input logic [1:0] m, input logic [W-1:0] t,
            input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] c);
        rst = r; cmp_en = en; out_en = oe; od_sel = od; inv_en = inv; mode = m;
        thr_level = t; margin_hi = hi; margin_lo = lo; code_in = c;
        @(posedge clk);
        if (r) begin
            res_exp = 1'b0;
            err_exp = 1'b0;
        end else begin
            res_exp = model_next(en, m, t, hi, lo, c, res_exp);
            if (en && m == 2'b11) err_exp = 1'b1;
        end
        @(negedge clk);
        if (!r) check_outputs();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        step(1'b1, 1, 1, 0, 0, 2'b11, 4'd0, 4'd0, 4'd0, 4'd15);
        // R1: reset state
        check("R1 status", status, 1'b0);
        check("R1 cfg_err", cfg_err, 1'b0);
        step(1'b1, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
        check("R1 pin_oe", pin_oe, 1'b0);
        check("R1 pin_do", pin_do, 1'b0);

        // R6 boundary: equal to threshold is 1, one below is 0
        step(0, 1, 1, 0, 0, 2'b00, 4'd7, 0, 0, 4'd7);
        step(0, 1, 1, 0, 0, 2'b00, 4'd7, 0, 0, 4'd6);
        // R7 walk: rise through band, set at hi, hold, clear at lo
        step(0, 1, 1, 1, 0, 2'b01, 0, 4'd10, 4'd4, 4'd8);
        step(0, 1, 1, 1, 0, 2'b01, 0, 4'd10, 4'd4, 4'd10);
        step(0, 1, 1, 1, 0, 2'b01, 0, 4'd10, 4'd4, 4'd5);
        step(0, 1, 1, 1, 1, 2'b01, 0, 4'd10, 4'd4, 4'd4);
        step(0, 1, 1, 1, 1, 2'b01, 0, 4'd10, 4'd4, 4'd9);
        // R8 bounds exclusive
        step(0, 1, 1, 0, 1, 2'b10, 0, 4'd9, 4'd3, 4'd3);
        step(0, 1, 1, 0, 1, 2'b10, 0, 4'd9, 4'd3, 4'd4);
        step(0, 1, 1, 0, 1, 2'b10, 0, 4'd9, 4'd3, 4'd9);
        // R10: status unaffected by inversion
        step(0, 1, 1, 0, 1, 2'b00, 4'd2, 0, 0, 4'd12);
        check("R10 status with inv", status, 1'b1);
        // R9: illegal mode then legal mode, error stays
        step(0, 1, 1, 0, 0, 2'b11, 4'd0, 0, 0, 4'd15);
        step(0, 1, 1, 0, 0, 2'b00, 4'd0, 0, 0, 4'd15);
        check("R9 sticky", cfg_err, 1'b1);
        // R2: disabled ignores illegal mode
        step(1, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
        step(0, 0, 1, 1, 1, 2'b11, 0, 0, 0, 4'd15);
        check("R2 no err when disabled", cfg_err, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            logic r;
            r = ($urandom % 200) == 0;
            step(r, ($urandom % 8) != 0, ($urandom % 4) != 0, 1'($urandom),
                 1'($urandom), ($urandom % 16 == 0) ? 2'b11 : 2'($urandom % 3),
                 W'($urandom), W'($urandom), W'($urandom), W'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule